// File: doc/BRIEF.md
# Extended Memory Field Mapper

This block extends the address reach of a 12-bit word-addressed processor from 32K to 128K words. Memory is split into 4K-word fields. The block keeps three 5-bit field registers: an instruction field, a buffered next instruction field and a data field. Decoded I/O-transfer (IOT) words load these registers. The field number comes from the instruction word itself, never from the accumulator.

Every memory reference the processor makes enters as a request carrying a cycle type and a 12-bit offset. The block picks the instruction field or the data field for that request. It passes the chosen field through an eight-entry remap table, which can place any of the 32 physical fields into any of the eight low logical slots. The result is a 17-bit physical address together with two decoded selects:
- a one-hot select naming one of the four 32K-word boards;
- a one-hot select naming the field within that board, which stays silent for the internal field 0.

Requests and results use valid/ready handshakes. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output register is empty or is being drained in the same cycle. A result that is presented and not accepted holds all its output fields unchanged until `out_ready` rises. The IOT inputs and `jmp_commit` are plain single-cycle strobes with no handshake.

Top module: `xfield_map`

## Requirements
- R1: After reset the instruction field, the buffered instruction field and the data field are all 0. Remap entry k holds k, so the mapping is the identity. `out_valid` is 0 and `req_ready` is 1.
- R2: A request taken at a clock edge appears on the outputs (`out_valid` = 1) right after that edge. `phys_addr[11:0]` equals the request offset, and `phys_addr[16:12]` is the mapped field.
- R3: Cycle type 2'b01 (deferred operand) uses the data field. Cycle types 2'b00 (fetch), 2'b10 (execute) and 2'b11 (treated as execute) use the instruction field.
- R4: A field IOT word has bits [11:9] = 3'b110 and bits [8:6] = 3'b010 + H, where H is 0 to 3. Bits [5:3] hold L and bits [2:0] hold the operation. Operation 3'b001 or 3'b011 loads the data field with {H, L}. The new value applies from the next clock edge.
- R5: Operation 3'b010 or 3'b011 loads {H, L} only into the buffered instruction field. A one-cycle `jmp_commit` pulse copies the buffered field into the instruction field.
- R6: If `jmp_commit` and an instruction-field load happen in the same cycle, the instruction field takes the buffered value held before that edge, and the buffer takes the new value.
- R7: A remap IOT word has bits [11:9] = 3'b110, bits [8:6] = 3'b110 and bits [2:0] = 3'b001. It writes `iot_ac[4:0]` into remap entry bits [5:3]. Logical fields 0 to 7 are translated through their remap entries. Logical fields 8 to 31 pass through unchanged.
- R8: `board_sel` is the one-hot decode of `phys_addr[16:15]`.
- R9: `fld_sel` is the one-hot decode of `phys_addr[14:12]`, except that it is all zero when the mapped field is 0.
- R10: While `out_valid` is 1 and `out_ready` is 0, `req_ready` is 0 and all outputs hold. Otherwise `req_ready` is 1.
- R11: IOT words that match neither format are ignored. This covers bits [11:9] other than 3'b110, group 3'b111, group 3'b000 or 3'b001, field operations 3'b000 or 3'b1xx, and remap operations other than 3'b001.
- R12: A request taken in the same cycle as an IOT uses the field state from before that IOT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iot_valid | input | 1 | Strobe: `iot_word` holds an instruction this cycle |
| iot_word | input | 12 | Instruction word to decode |
| iot_ac | input | 5 | Accumulator low bits, used only by the remap write |
| jmp_commit | input | 1 | Pulse at a jump or call: commit the buffered instruction field |
| req_valid | input | 1 | Memory reference request valid |
| req_ready | output | 1 | Request can be taken |
| req_cycle | input | 2 | Cycle type: 00 fetch, 01 defer, 10/11 execute |
| req_addr | input | 12 | Offset within the field |
| out_valid | output | 1 | Physical address valid |
| out_ready | input | 1 | Consumer takes the result |
| phys_addr | output | 17 | Mapped field and offset |
| board_sel | output | 4 | One-hot 32K-word board select |
| fld_sel | output | 8 | One-hot field-within-board select, zero for field 0 |

## Verification
The assertions assume the consumer follows the handshake: a result that is held is only released by `out_ready`. They also assume `req_addr` stays stable while a request waits for `req_ready`. The stimulus keeps to this because the driver changes request inputs only after a transfer at a clock edge.

The bench drives `jmp_commit` and IOT strobes only as single-cycle pulses. It pairs a request with an IOT only when `req_ready` is already high, so the old-state rule of R12 is checked on a definite cycle.

// File: rtl/xfield_map_pkg.sv
package xfield_map_pkg;
  // Memory reference cycle types seen on req_cycle.
  typedef enum logic [1:0] {
    CYC_FETCH = 2'b00,
    CYC_DEFER = 2'b01,
    CYC_EXEC  = 2'b10,
    CYC_EXEC2 = 2'b11
  } cycle_e;

  // Fixed IOT word layout: major opcode, group, operand, operation.
  localparam logic [2:0] IOT_MAJOR    = 3'b110;
  localparam logic [2:0] FLD_GRP_BASE = 3'b010;
  localparam int         WORD_W       = 12;
  localparam int         GRP_W        = 3;
  localparam int         OPN_W        = 3;
endpackage

// File: rtl/xfield_iot_decode.sv
module xfield_iot_decode
  import xfield_map_pkg::*;
#(
  parameter int HI_W = 2,
  parameter int LO_W = 3,
  localparam int FLD_W  = HI_W + LO_W,
  localparam int NBOARD = 1 << HI_W
) (
  input  logic              iot_valid,
  input  logic [WORD_W-1:0] iot_word,
  input  logic [FLD_W-1:0]  iot_ac,
  output logic              ld_df,
  output logic              ld_ib,
  output logic              ld_map,
  output logic [FLD_W-1:0]  fld_val,
  output logic [LO_W-1:0]   map_slot,
  output logic [FLD_W-1:0]  map_val
);
  localparam logic [GRP_W-1:0] MAP_GRP = FLD_GRP_BASE + GRP_W'(NBOARD);

  logic [2:0]       major;
  logic [GRP_W-1:0] grp;
  logic [LO_W-1:0]  lo;
  logic [OPN_W-1:0] opn;
  logic [GRP_W-1:0] grp_rel;
  logic             is_iot;
  logic             is_fld_grp;
  logic             fld_opn_ok;

  assign major   = iot_word[WORD_W-1 -: 3];
  assign grp     = iot_word[WORD_W-4 -: GRP_W];
  assign lo      = iot_word[OPN_W +: LO_W];
  assign opn     = iot_word[OPN_W-1:0];
  assign grp_rel = grp - FLD_GRP_BASE;

  always_comb begin
    is_iot     = iot_valid && (major == IOT_MAJOR);
    is_fld_grp = (grp >= FLD_GRP_BASE) && (grp < MAP_GRP);
    fld_opn_ok = !opn[2] && (opn[1:0] != 2'b00);
    ld_df      = is_iot && is_fld_grp && fld_opn_ok && opn[0];
    ld_ib      = is_iot && is_fld_grp && fld_opn_ok && opn[1];
    ld_map     = is_iot && (grp == MAP_GRP) && (opn == 3'b001);
    fld_val    = {grp_rel[HI_W-1:0], lo};
    map_slot   = lo;
    map_val    = iot_ac;
  end
endmodule

// File: rtl/xfield_regs.sv
module xfield_regs
  import xfield_map_pkg::*;
#(
  parameter int FLD_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_df,
  input  logic             ld_ib,
  input  logic [FLD_W-1:0] fld_val,
  input  logic             jmp_commit,
  input  cycle_e           cyc,
  output logic [FLD_W-1:0] cur_fld
);
  logic [FLD_W-1:0] if_q;
  logic [FLD_W-1:0] ib_q;
  logic [FLD_W-1:0] df_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if_q <= '0;
      ib_q <= '0;
      df_q <= '0;
    end else begin
      if (ld_df)      df_q <= fld_val;
      if (ld_ib)      ib_q <= fld_val;
      if (jmp_commit) if_q <= ib_q;
    end
  end

  always_comb begin
    unique case (cyc)
      CYC_DEFER: cur_fld = df_q;
      default:   cur_fld = if_q;
    endcase
  end
endmodule

// File: rtl/xfield_remap.sv
module xfield_remap #(
  parameter int HI_W = 2,
  parameter int LO_W = 3,
  localparam int FLD_W = HI_W + LO_W,
  localparam int SLOTS = 1 << LO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LO_W-1:0]  wr_slot,
  input  logic [FLD_W-1:0] wr_val,
  input  logic [FLD_W-1:0] lfield,
  output logic [FLD_W-1:0] pfield
);
  logic [FLD_W-1:0] entry [SLOTS];

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        entry[k] <= FLD_W'(k);
      end else if (wr_en && (wr_slot == LO_W'(k))) begin
        entry[k] <= wr_val;
      end
    end
  end

  // Only the low slots are translated; upper fields pass straight through.
  always_comb begin
    if (lfield[FLD_W-1:LO_W] == '0) pfield = entry[lfield[LO_W-1:0]];
    else                            pfield = lfield;
  end
endmodule

// File: rtl/xfield_out_stage.sv
module xfield_out_stage #(
  parameter int HI_W  = 2,
  parameter int LO_W  = 3,
  parameter int OFS_W = 12,
  localparam int FLD_W  = HI_W + LO_W,
  localparam int PA_W   = FLD_W + OFS_W,
  localparam int NBOARD = 1 << HI_W,
  localparam int SLOTS  = 1 << LO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [OFS_W-1:0]  req_addr,
  input  logic [FLD_W-1:0]  pfield,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PA_W-1:0]   phys_addr,
  output logic [NBOARD-1:0] board_sel,
  output logic [SLOTS-1:0]  fld_sel
);
  logic [NBOARD-1:0] board_d;
  logic [SLOTS-1:0]  fld_d;
  logic              take;

  for (genvar b = 0; b < NBOARD; b++) begin : g_board
    assign board_d[b] = (pfield[FLD_W-1:LO_W] == HI_W'(b));
  end

  for (genvar f = 0; f < SLOTS; f++) begin : g_fld
    if (f == 0) begin : g_internal
      assign fld_d[f] = (pfield == '0) ? 1'b0 : (pfield[LO_W-1:0] == '0);
    end else begin : g_external
      assign fld_d[f] = (pfield[LO_W-1:0] == LO_W'(f));
    end
  end

  assign req_ready = !out_valid || out_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      phys_addr <= '0;
      board_sel <= '0;
      fld_sel   <= '0;
    end else if (req_ready) begin
      out_valid <= req_valid;
      if (take) begin
        phys_addr <= {pfield, req_addr};
        board_sel <= board_d;
        fld_sel   <= fld_d;
      end
    end
  end
endmodule

// File: rtl/xfield_map.sv
module xfield_map
  import xfield_map_pkg::*;
#(
  parameter int HI_W  = 2,
  parameter int LO_W  = 3,
  parameter int OFS_W = 12,
  localparam int FLD_W  = HI_W + LO_W,
  localparam int PA_W   = FLD_W + OFS_W,
  localparam int NBOARD = 1 << HI_W,
  localparam int SLOTS  = 1 << LO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iot_valid,
  input  logic [11:0]       iot_word,
  input  logic [FLD_W-1:0]  iot_ac,
  input  logic              jmp_commit,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_cycle,
  input  logic [OFS_W-1:0]  req_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PA_W-1:0]   phys_addr,
  output logic [NBOARD-1:0] board_sel,
  output logic [SLOTS-1:0]  fld_sel
);
  logic             ld_df;
  logic             ld_ib;
  logic             ld_map;
  logic [FLD_W-1:0] fld_val;
  logic [LO_W-1:0]  map_slot;
  logic [FLD_W-1:0] map_val;
  logic [FLD_W-1:0] cur_fld;
  logic [FLD_W-1:0] pfield;
  cycle_e           cyc;

  assign cyc = cycle_e'(req_cycle);

  xfield_iot_decode #(.HI_W(HI_W), .LO_W(LO_W)) i_dec (
    .iot_valid (iot_valid),
    .iot_word  (iot_word),
    .iot_ac    (iot_ac),
    .ld_df     (ld_df),
    .ld_ib     (ld_ib),
    .ld_map    (ld_map),
    .fld_val   (fld_val),
    .map_slot  (map_slot),
    .map_val   (map_val)
  );

  xfield_regs #(.FLD_W(FLD_W)) i_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_df      (ld_df),
    .ld_ib      (ld_ib),
    .fld_val    (fld_val),
    .jmp_commit (jmp_commit),
    .cyc        (cyc),
    .cur_fld    (cur_fld)
  );

  xfield_remap #(.HI_W(HI_W), .LO_W(LO_W)) i_remap (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ld_map),
    .wr_slot (map_slot),
    .wr_val  (map_val),
    .lfield  (cur_fld),
    .pfield  (pfield)
  );

  xfield_out_stage #(.HI_W(HI_W), .LO_W(LO_W), .OFS_W(OFS_W)) i_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .pfield    (pfield),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .phys_addr (phys_addr),
    .board_sel (board_sel),
    .fld_sel   (fld_sel)
  );
endmodule

// File: rtl/xfield_map_chk.sv
module xfield_map_chk #(
  parameter int HI_W  = 2,
  parameter int LO_W  = 3,
  parameter int OFS_W = 12,
  localparam int FLD_W  = HI_W + LO_W,
  localparam int PA_W   = FLD_W + OFS_W,
  localparam int NBOARD = 1 << HI_W,
  localparam int SLOTS  = 1 << LO_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [OFS_W-1:0]  req_addr,
  input logic              out_valid,
  input logic              out_ready,
  input logic [PA_W-1:0]   phys_addr,
  input logic [NBOARD-1:0] board_sel,
  input logic [SLOTS-1:0]  fld_sel
);
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> out_valid && (phys_addr[OFS_W-1:0] == $past(req_addr))); // R2

  AST_ONE_BOARD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(board_sel) == 1)); // R8

  AST_BOARD_TRACKS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> board_sel[phys_addr[PA_W-1 -: HI_W]]); // R8

  AST_FLD_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fld_sel)); // R9

  AST_INTERNAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (phys_addr[PA_W-1:OFS_W] == '0) |-> (fld_sel == '0)); // R9

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !req_ready); // R10

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(phys_addr) && $stable(board_sel)
                                && $stable(fld_sel)); // R10
endmodule

bind xfield_map xfield_map_chk #(.HI_W(HI_W), .LO_W(LO_W), .OFS_W(OFS_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .phys_addr (phys_addr),
  .board_sel (board_sel),
  .fld_sel   (fld_sel)
);

// File: tb/test_xfield_map.sv
`timescale 1ns/1ps
module test_xfield_map;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iot_valid = 1'b0;
  logic [11:0] iot_word = '0;
  logic [4:0]  iot_ac = '0;
  logic        jmp_commit = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_cycle = '0;
  logic [11:0] req_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [16:0] phys_addr;
  logic [3:0]  board_sel;
  logic [7:0]  fld_sel;

  int vectors = 0;
  int misses  = 0;
  bit finished = 0;

  // Reference state, built from the requirements.
  logic [4:0] m_if = '0, m_ib = '0, m_df = '0;
  logic [4:0] m_map [8];

  typedef struct packed {
    logic [16:0] pa;
    logic [3:0]  bs;
    logic [7:0]  fs;
    logic [7:0]  tag;
  } exp_t;
  exp_t expq [$];
  logic [7:0] cur_tag = 8'd2;

  always #2 clk = ~clk;

  xfield_map i_xfield_map (
    .clk(clk), .rst_n(rst_n), .iot_valid(iot_valid), .iot_word(iot_word),
    .iot_ac(iot_ac), .jmp_commit(jmp_commit), .req_valid(req_valid),
    .req_ready(req_ready), .req_cycle(req_cycle), .req_addr(req_addr),
    .out_valid(out_valid), .out_ready(out_ready), .phys_addr(phys_addr),
    .board_sel(board_sel), .fld_sel(fld_sel)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    vectors++;
    if (act !== expv) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic exp_t predict(input logic [1:0] cyc, input logic [11:0] a);
    logic [4:0] lf, pf;
    exp_t e;
    lf = (cyc == 2'b01) ? m_df : m_if;               // R3
    pf = (lf < 5'd8) ? m_map[lf[2:0]] : lf;          // R7
    e.pa  = {pf, a};                                 // R2
    e.bs  = 4'b0001 << pf[4:3];                      // R8
    e.fs  = (pf == 5'd0) ? 8'h00 : (8'h01 << pf[2:0]); // R9
    e.tag = cur_tag;
    return e;
  endfunction

  // Reference decode of one IOT word (R4, R5, R6, R7, R11).
  task automatic model_iot(input logic [11:0] w, input logic [4:0] ac, input bit jc);
    logic [2:0] g, l, o;
    logic [4:0] old_ib;
    g = w[8:6]; l = w[5:3]; o = w[2:0];
    old_ib = m_ib;
    if (w[11:9] == 3'b110 && g >= 3'd2 && g <= 3'd5 && (o == 3'd1 || o == 3'd2 || o == 3'd3)) begin
      if (o[0]) m_df = {2'(g - 3'd2), l};
      if (o[1]) m_ib = {2'(g - 3'd2), l};
    end
    if (w[11:9] == 3'b110 && g == 3'd6 && o == 3'd1) m_map[l] = ac;
    if (jc) m_if = old_ib;
  endtask

  // All tasks start and end 1 ns after a rising edge.
  task automatic do_iot(input logic [11:0] w, input logic [4:0] ac = 5'd0, input bit jc = 0);
    iot_word = w; iot_ac = ac; iot_valid = 1'b1; jmp_commit = jc;
    @(posedge clk); #1;
    iot_valid = 1'b0; jmp_commit = 1'b0;
    model_iot(w, ac, jc);
  endtask

  task automatic commit();
    jmp_commit = 1'b1;
    @(posedge clk); #1;
    jmp_commit = 1'b0;
    m_if = m_ib;
  endtask

  task automatic do_req(input logic [1:0] cyc, input logic [11:0] a);
    req_cycle = cyc; req_addr = a; req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    expq.push_back(predict(cyc, a));
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  // Request taken in the same cycle as an IOT sees the old state (R12).
  task automatic req_with_iot(input logic [1:0] cyc, input logic [11:0] a, input logic [11:0] w);
    @(negedge clk);
    check("R12 ready before paired request", {31'd0, req_ready}, 32'd1);
    expq.push_back(predict(cyc, a));
    @(posedge clk); #1;
    req_cycle = cyc; req_addr = a; req_valid = 1'b1;
    iot_word = w; iot_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0; iot_valid = 1'b0;
    model_iot(w, 5'd0, 0);
  endtask

  task automatic drain();
    while (expq.size() != 0) @(posedge clk);
    #1;
  endtask

  // Monitor: a transfer completes at the next edge when both are high here.
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (expq.size() == 0) begin
        check("R2 unexpected result", {15'd0, phys_addr}, 32'hFFFFFFFF);
      end else begin
        exp_t e;
        string r;
        e = expq.pop_front();
        r = $sformatf("R%0d phys_addr", e.tag);
        check(r, {15'd0, phys_addr}, {15'd0, e.pa});
        check("R8 board_sel", {28'd0, board_sel}, {28'd0, e.bs});
        check("R9 fld_sel", {24'd0, fld_sel}, {24'd0, e.fs});
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) m_map[k] = 5'(k);
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
    check("R1 req_ready after reset", {31'd0, req_ready}, 32'd1);
    @(posedge clk); #1;

    cur_tag = 8'd1;
    do_req(2'b00, 12'o0000);          // field 0 internal: fld_sel 0 (R9)
    do_req(2'b01, 12'o7777);
    do_req(2'b10, 12'o1234);
    drain();

    cur_tag = 8'd4;
    do_iot(12'o6251);                 // data field 5
    do_req(2'b01, 12'o0100);          // R3 defer uses data field
    do_req(2'b00, 12'o0101);          // fetch still field 0
    do_iot(12'o6531);                 // data field 27
    do_req(2'b01, 12'o4567);
    drain();

    cur_tag = 8'd5;
    do_iot(12'o6362);                 // buffered instruction field 14
    do_req(2'b00, 12'o0200);          // not yet committed
    do_req(2'b01, 12'o0201);          // data field unchanged (27)
    commit();
    do_req(2'b00, 12'o0202);
    do_req(2'b11, 12'o0203);
    do_iot(12'o6313);                 // both fields 9
    do_req(2'b01, 12'o0204);
    do_req(2'b10, 12'o0205);          // still 14 before commit
    commit();
    do_req(2'b10, 12'o0206);
    drain();

    cur_tag = 8'd11;
    do_iot(12'o6701);
    do_iot(12'o6250);
    do_iot(12'o6254);
    do_iot(12'o6602, 5'd17);
    do_iot(12'o5251);
    do_iot(12'o6051);
    do_req(2'b01, 12'o0300);          // fields must still be 9 / 9
    do_req(2'b00, 12'o0301);
    drain();

    cur_tag = 8'd7;
    do_iot(12'o6621, 5'd20);          // slot 2 -> field 20
    do_iot(12'o6221);                 // data field 2
    do_req(2'b01, 12'o0400);
    do_iot(12'o6441);                 // data field 20 passes through
    do_req(2'b01, 12'o0401);
    do_iot(12'o6601, 5'd30);          // slot 0 -> field 30
    do_iot(12'o6201);
    do_req(2'b01, 12'o0402);
    drain();

    cur_tag = 8'd6;
    do_iot(12'o6232, 5'd0, 1);        // IF takes old buffer 9, buffer takes 3
    do_req(2'b00, 12'o0500);
    commit();
    do_req(2'b00, 12'o0501);
    drain();

    cur_tag = 8'd12;
    req_with_iot(2'b01, 12'o0600, 12'o6271);   // data field 7 loaded with the request
    cur_tag = 8'd4;
    do_req(2'b01, 12'o0601);
    drain();

    // Back-pressure (R10)
    cur_tag = 8'd10;
    out_ready = 1'b0;
    fork
      begin
        do_req(2'b00, 12'o0700);
        do_req(2'b01, 12'o0701);
      end
      begin
        logic [16:0] held;
        repeat (2) @(negedge clk);
        held = phys_addr;
        check("R10 valid under stall", {31'd0, out_valid}, 32'd1);
        check("R10 ready low under stall", {31'd0, req_ready}, 32'd0);
        repeat (3) @(negedge clk);
        check("R10 held address", {15'd0, phys_addr}, {15'd0, held});
        check("R10 ready still low", {31'd0, req_ready}, 32'd0);
        @(posedge clk); #1;
        out_ready = 1'b1;
      end
    join
    drain();

    // Mixed stream with random back-pressure (R2, R3, R8, R10)
    cur_tag = 8'd3;
    begin
      bit stop = 0;
      fork
        begin
          for (int n = 0; n < 40; n++) begin
            if (n % 10 == 5) do_iot({3'b110, 3'(2 + $urandom_range(0, 3)), 3'($urandom_range(0, 7)), 3'b011});
            if (n % 10 == 7) commit();
            do_req(2'($urandom_range(0, 3)), 12'($urandom));
          end
          stop = 1;
        end
        begin
          while (!stop) begin
            @(posedge clk); #1;
            out_ready = ($urandom_range(0, 2) != 0);
          end
        end
      join
    end
    out_ready = 1'b1;
    drain();
    repeat (2) @(posedge clk);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule